// File: doc/BRIEF.md
# Rotate Unit with Carry

This block is the rotate stage of a processor datapath. It takes a 32-bit operand and either rotates it right by a programmable amount, or rotates it right by a single place through the carry flag, so that the incoming carry enters the top bit. It also works out the next value of the carry flag. Only the flag-setting forms of an operation may change that flag. When flag updates are disabled, the carry input passes straight through to the carry output.

The result and the next carry are purely combinational. The amount input is 8 bits wide and is reduced modulo the data width. An amount of zero is a special case, and so is any nonzero multiple of 32. A parameter can add a carry flag register that loads the new carry on each clock edge where updates are enabled. The register clears to zero on a synchronous reset.

Top module: `rot_carry_unit`

## Requirements
- R1: With `mode_i` = 0 (rotate by amount) and an effective amount n in 1..31, result bit i equals operand bit (i+n) mod 32. The low n operand bits reappear as the top n result bits.
- R2: With `mode_i` = 0, `upd_i` = 1 and an effective amount n in 1..31, `carry_o` equals operand bit n-1.
- R3: Amounts of 32 or more use only the low 5 bits of `amount_i` as the effective amount. For example, 33 acts as 1 and 95 acts as 31.
- R4: With `mode_i` = 0 and a nonzero amount that is a multiple of 32 (32, 64, 96 ... 224), the result equals the operand. If `upd_i` = 1, `carry_o` equals operand bit 31.
- R5: With `mode_i` = 0 and `amount_i` = 0, the result equals the operand and `carry_o` equals `carry_i`, whatever the value of `upd_i`.
- R6: With `mode_i` = 1 (rotate through carry), the result is `{carry_i, operand_i[31:1]}`, and `amount_i` has no effect.
- R7: With `mode_i` = 1 and `upd_i` = 1, `carry_o` equals operand bit 0.
- R8: With `upd_i` = 0, `carry_o` equals `carry_i` in both modes.
- R9: On a rising clock edge with `rst` low, `carry_q_o` loads `carry_o` if `upd_i` = 1 and otherwise keeps its value.
- R10: A rising edge with `rst` high clears `carry_q_o` to 0, whatever `upd_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high |
| operand_i | input | 32 | Value to rotate |
| amount_i | input | 8 | Rotate amount (ignored in mode 1) |
| mode_i | input | 1 | 0 = rotate by amount, 1 = rotate one place through carry |
| carry_i | input | 1 | Incoming carry flag |
| upd_i | input | 1 | Flag update enable |
| result_o | output | 32 | Rotated value |
| carry_o | output | 1 | Next carry flag (combinational) |
| carry_q_o | output | 1 | Registered carry flag |

## Verification
Each stimulus goes to a reference model that shifts bit by bit, and the model's result, carry and flag-register value are queued for a scoreboard. The amounts 1 and 31 probe the two ends of the wrap. The amounts 32, 64 and 224 can only be told apart from 0 by their carry behaviour. The amounts 33, 63 and 255 show whether the upper amount bits are discarded. In rotate-through-carry mode, each vector is also driven with several unrelated amounts, which shows that the amount is ignored. Random vectors with both modes and both update settings cover the carry-hold path, and the flag register is followed across runs of enabled and disabled updates.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
   typedef enum logic {
      RCU_ROT_N  = 1'b0,
      RCU_ROT_XC = 1'b1
   } rcu_mode_e;
endpackage

// File: rtl/rcu_amount_reduce.sv
module rcu_amount_reduce #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [AMT_W-1:0] amount_i,
   output logic [SH_W-1:0]  eff_o,
   output logic             zero_o,
   output logic             full_o
);
   // Reduce modulo the data width (a power of two): keep the low bits.
   generate
      if (AMT_W > SH_W) begin : g_trunc
         assign eff_o = amount_i[SH_W-1:0];
      end else begin : g_ext
         assign eff_o = SH_W'(amount_i);
      end
   endgenerate

   assign zero_o = (amount_i == '0);
   // Nonzero multiple of the width: acts like a rotation by the full width.
   assign full_o = !zero_o && (eff_o == '0);
endmodule

// File: rtl/rcu_barrel.sv
module rcu_barrel #(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [SH_W-1:0]   amt_i,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] stg [0:SH_W];

   assign stg[0] = data_i;

   // Logarithmic rotator: stage k rotates right by 2**k when amount bit k is set.
   generate
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         localparam int S = 2 ** k;
         assign stg[k+1] = amt_i[k] ? {stg[k][S-1:0], stg[k][DATA_W-1:S]} : stg[k];
      end
   endgenerate

   assign data_o = stg[SH_W];
endmodule

// File: rtl/rcu_carry_sel.sv
module rcu_carry_sel
   import rcu_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  rcu_mode_e         mode_i,
   input  logic [DATA_W-1:0] operand_i,
   input  logic [DATA_W-1:0] rotated_i,
   input  logic [SH_W-1:0]   eff_i,
   input  logic              zero_i,
   input  logic              full_i,
   input  logic              carry_i,
   input  logic              upd_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   logic [SH_W-1:0] tap;
   logic            rot_carry;

   // The last bit rotated out is operand bit (n-1).
   assign tap       = eff_i - SH_W'(1);
   assign rot_carry = full_i ? operand_i[DATA_W-1] : operand_i[tap];

   always_comb begin
      result_o = rotated_i;
      carry_o  = carry_i;
      unique case (mode_i)
         RCU_ROT_XC: begin
            result_o = {carry_i, operand_i[DATA_W-1:1]};
            if (upd_i) carry_o = operand_i[0];
         end
         default: begin
            if (upd_i && !zero_i) carry_o = rot_carry;
         end
      endcase
   end
endmodule

// File: rtl/rcu_flag_reg.sv
module rcu_flag_reg #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic upd_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (ENABLE) begin : g_reg
         logic q;
         always_ff @(posedge clk) begin
            if (rst)        q <= 1'b0;
            else if (upd_i) q <= d_i;
         end
         assign q_o = q;
      end else begin : g_none
         logic unused;
         assign unused = clk ^ rst ^ upd_i ^ d_i;
         assign q_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rot_carry_unit.sv
module rot_carry_unit
   import rcu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int AMT_W    = 8,
   parameter bit REG_FLAG = 1'b1,
   localparam int SH_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] operand_i,
   input  logic [AMT_W-1:0]  amount_i,
   input  logic              mode_i,
   input  logic              carry_i,
   input  logic              upd_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic              carry_q_o
);
   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("rot_carry_unit: DATA_W must be a power of two >= 2");
      end
      if (AMT_W < 1) begin : g_bad_amt
         $error("rot_carry_unit: AMT_W must be at least 1");
      end
   endgenerate

   logic [SH_W-1:0]   eff;
   logic              amt_zero, amt_full;
   logic [DATA_W-1:0] rotated;
   rcu_mode_e         mode;

   assign mode = rcu_mode_e'(mode_i);

   rcu_amount_reduce #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_reduce (
      .amount_i (amount_i),
      .eff_o    (eff),
      .zero_o   (amt_zero),
      .full_o   (amt_full)
   );

   rcu_barrel #(.DATA_W(DATA_W)) i_barrel (
      .data_i (operand_i),
      .amt_i  (eff),
      .data_o (rotated)
   );

   rcu_carry_sel #(.DATA_W(DATA_W)) i_sel (
      .mode_i    (mode),
      .operand_i (operand_i),
      .rotated_i (rotated),
      .eff_i     (eff),
      .zero_i    (amt_zero),
      .full_i    (amt_full),
      .carry_i   (carry_i),
      .upd_i     (upd_i),
      .result_o  (result_o),
      .carry_o   (carry_o)
   );

   rcu_flag_reg #(.ENABLE(REG_FLAG)) i_flag (
      .clk   (clk),
      .rst   (rst),
      .upd_i (upd_i),
      .d_i   (carry_o),
      .q_o   (carry_q_o)
   );
endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
   parameter int DATA_W   = 32,
   parameter int AMT_W    = 8,
   parameter bit REG_FLAG = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] operand_i,
   input logic [AMT_W-1:0]  amount_i,
   input logic              mode_i,
   input logic              carry_i,
   input logic              upd_i,
   input logic [DATA_W-1:0] result_o,
   input logic              carry_o,
   input logic              carry_q_o
);
   localparam int SH_W = $clog2(DATA_W);

   logic low_zero;
   assign low_zero = (amount_i[SH_W-1:0] == '0);

   assert_rot_one_R1: assert property (@(posedge clk) disable iff (rst)
      (!mode_i && amount_i == AMT_W'(1)) |-> result_o == {operand_i[0], operand_i[DATA_W-1:1]});

   // The bit rotated out last lands in the top result bit.
   assert_rot_carry_R2: assert property (@(posedge clk) disable iff (rst)
      (!mode_i && upd_i && !low_zero) |-> carry_o == result_o[DATA_W-1]);

   assert_full_identity_R4: assert property (@(posedge clk) disable iff (rst)
      (!mode_i && amount_i != '0 && low_zero) |-> result_o == operand_i);

   assert_zero_amount_R5: assert property (@(posedge clk) disable iff (rst)
      (!mode_i && amount_i == '0) |-> (result_o == operand_i && carry_o == carry_i));

   assert_xc_result_R6: assert property (@(posedge clk) disable iff (rst)
      mode_i |-> result_o == {carry_i, operand_i[DATA_W-1:1]});

   assert_xc_carry_R7: assert property (@(posedge clk) disable iff (rst)
      (mode_i && upd_i) |-> carry_o == operand_i[0]);

   assert_hold_carry_R8: assert property (@(posedge clk) disable iff (rst)
      !upd_i |-> carry_o == carry_i);

   generate
      if (REG_FLAG) begin : g_reg_chk
         assert_flag_load_R9: assert property (@(posedge clk) disable iff (rst)
            upd_i |=> carry_q_o == $past(carry_o));
         assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
            !upd_i |=> $stable(carry_q_o));
         assert_flag_reset_R10: assert property (@(posedge clk)
            rst |=> !carry_q_o);
      end
   endgenerate
endmodule

bind rot_carry_unit rcu_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W), .REG_FLAG(REG_FLAG)) i_rcu_checker (
   .clk       (clk),
   .rst       (rst),
   .operand_i (operand_i),
   .amount_i  (amount_i),
   .mode_i    (mode_i),
   .carry_i   (carry_i),
   .upd_i     (upd_i),
   .result_o  (result_o),
   .carry_o   (carry_o),
   .carry_q_o (carry_q_o)
);

// File: tb/test_rot_carry_unit.sv
module test_rot_carry_unit;
   localparam int W = 32;

   typedef struct {
      logic [W-1:0] res;
      logic         c;
      logic         q;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] operand = '0;
   logic [7:0]   amount = '0;
   logic         mode = 1'b0;
   logic         carry = 1'b0;
   logic         upd = 1'b0;
   logic [W-1:0] result;
   logic         carry_n, carry_q;

   int   n_run = 0;
   int   n_fail = 0;
   logic model_q = 1'b0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   rot_carry_unit i_rot_carry_unit (
      .clk       (clk),
      .rst       (rst),
      .operand_i (operand),
      .amount_i  (amount),
      .mode_i    (mode),
      .carry_i   (carry),
      .upd_i     (upd),
      .result_o  (result),
      .carry_o   (carry_n),
      .carry_q_o (carry_q)
   );

   // Reference model built bit by bit from the requirements.
   function automatic void ref_model(input logic [W-1:0] op, input logic [7:0] amt,
                                     input logic m, input logic ci, input logic up,
                                     output logic [W-1:0] r, output logic c);
      int n;
      n = amt % W;
      c = ci;
      if (m) begin
         r = {ci, op[W-1:1]};
         if (up) c = op[0];
      end else begin
         for (int i = 0; i < W; i++) r[i] = op[(i + n) % W];
         if (up && amt != 0) c = (n == 0) ? op[W-1] : op[n-1];
      end
   endfunction

   // Driver: apply one vector at the falling edge and queue the expectation.
   task automatic drive(input logic [W-1:0] op, input logic [7:0] amt, input logic m,
                        input logic ci, input logic up, input logic r, input string tag);
      exp_t e;
      @(negedge clk);
      operand = op; amount = amt; mode = m; carry = ci; upd = up; rst = r;
      ref_model(op, amt, m, ci, up, e.res, e.c);
      if (r)       model_q = 1'b0;
      else if (up) model_q = e.c;
      e.q = model_q;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: after each rising edge compare outputs against the oldest expectation.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (result !== e.res) begin
               n_fail++;
               $display("FAIL %s result: actual %h expected %h", e.tag, result, e.res);
            end
            n_run++;
            if (carry_n !== e.c) begin
               n_fail++;
               $display("FAIL %s carry_o: actual %b expected %b", e.tag, carry_n, e.c);
            end
            n_run++;
            if (carry_q !== e.q) begin
               n_fail++;
               $display("FAIL %s carry_q_o: actual %b expected %b", e.tag, carry_q, e.q);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pat;
      pat = 32'h8000_0001;
      // R10: reset state and reset priority over update
      drive(32'h0000_0001, 8'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R10 reset");
      drive(32'h0000_0001, 8'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R10 reset with upd");

      // R5: amount zero
      drive(32'hDEAD_BEEF, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R5 amt0 c1");
      drive(32'hDEAD_BEEF, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 amt0 c0");
      // R1/R2: ends of the wrap
      drive(32'h0000_0001, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R1 R2 amt1");
      drive(32'h1234_5678, 8'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R1 R2 amt1 even");
      drive(32'h8000_0000, 8'd31, 1'b0, 1'b0, 1'b1, 1'b0, "R1 R2 amt31");
      drive(32'h4000_0000, 8'd31, 1'b0, 1'b1, 1'b1, 1'b0, "R1 R2 amt31 b30");
      drive(32'h0000_0004, 8'd3, 1'b0, 1'b0, 1'b1, 1'b0, "R1 R2 amt3");
      // R4: multiples of 32
      drive(32'h8000_0000, 8'd32, 1'b0, 1'b0, 1'b1, 1'b0, "R4 amt32 b31=1");
      drive(32'h7FFF_FFFF, 8'd32, 1'b0, 1'b1, 1'b1, 1'b0, "R4 amt32 b31=0");
      drive(32'hA5A5_A5A5, 8'd64, 1'b0, 1'b0, 1'b1, 1'b0, "R4 amt64");
      drive(32'h0F0F_0F0F, 8'd224, 1'b0, 1'b1, 1'b1, 1'b0, "R4 amt224");
      // R3: reduction of large amounts
      drive(32'h0000_0001, 8'd33, 1'b0, 1'b0, 1'b1, 1'b0, "R3 amt33");
      drive(32'h8000_0000, 8'd63, 1'b0, 1'b0, 1'b1, 1'b0, "R3 amt63");
      drive(32'hCAFE_F00D, 8'd255, 1'b0, 1'b0, 1'b1, 1'b0, "R3 amt255");
      drive(pat, 8'd161, 1'b0, 1'b0, 1'b1, 1'b0, "R3 amt161");
      // R6/R7: through carry, amount ignored
      drive(32'h0000_0003, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 R7 xc c0");
      drive(32'h0000_0002, 8'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R6 R7 xc c1");
      foreach (pat[i]) begin
         if (i < 4) drive(32'hF00D_0001, 8'(i * 67 + 5), 1'b1, 1'b1, 1'b1, 1'b0, "R6 xc amount ignored");
      end
      // R8: update disabled
      drive(32'h0000_0001, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 rot hold");
      drive(32'h8000_0000, 8'd32, 1'b0, 1'b1, 1'b0, 1'b0, "R8 full hold");
      drive(32'h0000_0001, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 xc hold");
      // R9: register follows enabled updates, holds otherwise
      drive(32'h0000_0001, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 load 1");
      drive(32'h0000_0000, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 hold 1");
      drive(32'h0000_0000, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0, "R9 hold 1 again");
      drive(32'h0000_0000, 8'd5, 1'b0, 1'b1, 1'b1, 1'b0, "R9 load 0");
      drive(32'h0000_0001, 8'd9, 1'b0, 1'b0, 1'b1, 1'b1, "R10 reset mid-run");
      // Random mix in both modes
      for (int k = 0; k < 400; k++) begin
         logic [W-1:0] op;
         logic [7:0]   a;
         op = $urandom;
         a  = 8'($urandom);
         drive(op, a, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, "R1 R2 R3 R6 R7 R8 R9 random");
      end
      drive(32'h0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 final");
      wait (sb.size() == 0);
      @(posedge clk);
      #3;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule